// File: doc/BRIEF.md
# Implication-Logic Serial Adder

This block adds two 8-bit numbers and a carry-in. It has no adder gates. Its only storage is a row of single-bit state cells, and it changes them with two micro-operations. The clear operation writes 0 into one cell. The implication operation takes a source cell p and a target cell q, writes `(NOT p) OR q` back into q, and leaves p as it was. A built-in sequencer runs a fixed 23-operation program for each bit position, starting at the least significant bit. Each program destroys the operand cells of its own bit in place, and leaves the sum bit and the updated carry behind.

The cells are shared between bit positions. One carry cell serves every position. The operand cells of bit i-1 become the two scratch cells of bit i. Each bit writes its sum into a cell of its own that no later bit touches, so all sum bits are still held when the run ends. This gives 27 cells for 8 bits.

A caller pulses `start` with the operands present, waits for the one-cycle `done` pulse, and then reads `sum` and `carry_out`. A per-cycle trace shows which micro-operation runs and which cells it uses. A step counter shows how many operation cycles have run.

Top module: `imply_serial_adder`

## Requirements
- R1: An implication step on cells (p, q) leaves q equal to `(NOT p) OR q` as they held before the step, and leaves p unchanged.
- R2: A clear step leaves its target cell at 0, whatever it held before.
- R3: While busy, the trace shows the operation run in that cycle. `trace_kind` is 0 for clear and 1 for implication, and `trace_p` is 0 for a clear. Each bit runs 23 steps in this order, where X>Y means implication with p=X and q=Y: clear M1, clear M2, clear M3, A>M3, B>M2, M3>B, A>M2, M2>M1, B>M1, clear A, M1>A, clear B, clear M3, C>M3, M3>A, C>M1, M1>B, A>B, clear M3, B>M3, clear C, M2>C, M1>C.
- R4: The cell layout is as follows. C is cell 0. Bit i uses A=3i+3, B=3i+4 and M3=3i+5, and M3 is also its sum cell. For bit 0, M1 and M2 are cells 1 and 2. For bit i>0, M1 and M2 are cells 3i and 3i+1, which were the A and B cells of bit i-1. No step writes a sum cell of an earlier bit.
- R5: A `start` seen while idle loads the cells at that clock edge. Bit i of `op_a` goes to cell 3i+3, bit i of `op_b` goes to cell 3i+4, `carry_in` goes to cell 0, and all other cells become 0. `busy` is high from the next cycle on.
- R6: `busy` stays high for exactly 184 cycles, which is 8 bits times 23 steps. In each of those cycles `step_count` equals the number of steps already completed, and it reads 184 when `done` is high.
- R7: `done` is high for exactly one cycle, the cycle after the last step of bit 7, and `busy` is low in that cycle.
- R8: A `start` seen while `busy` is high has no effect on the schedule, the cells or the result.
- R9: When `done` is high, `{carry_out, sum}` equals `op_a + op_b + carry_in` for the loaded operands. The result holds until the next accepted `start`.
- R10: After reset, `busy`, `done`, `trace_valid`, `step_count`, `sum` and `carry_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an addition (accepted only when idle) |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| busy | output | 1 | Micro-operation program is running |
| done | output | 1 | One-cycle pulse after the final step |
| sum | output | 8 | Contents of the eight sum cells |
| carry_out | output | 1 | Contents of the shared carry cell |
| trace_valid | output | 1 | Trace fields describe an operation this cycle |
| trace_kind | output | 1 | 0 = clear, 1 = implication |
| trace_p | output | 5 | Source cell index (0 for clear) |
| trace_q | output | 5 | Target cell index |
| step_count | output | 8 | Operation cycles completed in the current or last run |

## Verification
The sum cells and the carry cell are visible at the ports, so a wrong write to any of them shows up at `sum` or `carry_out` one cycle after the faulty step. The bench compares them with its own cell model after every step. A wrong write to an operand or scratch cell is hidden at first. It appears when a later step of the same bit moves that value into M3 or C, which is at most 20 cycles later, and it changes the final result. The trace fields are compared in every busy cycle, so a wrong schedule or index mapping is seen in the cycle it happens.

// File: rtl/imp_pkg.sv
package imp_pkg;

  typedef enum logic {
    OP_CLEAR = 1'b0,
    OP_IMPLY = 1'b1
  } op_kind_e;

  typedef enum logic [2:0] {
    ROLE_A    = 3'd0,
    ROLE_B    = 3'd1,
    ROLE_C    = 3'd2,
    ROLE_M1   = 3'd3,
    ROLE_M2   = 3'd4,
    ROLE_M3   = 3'd5,
    ROLE_NONE = 3'd7
  } role_e;

  typedef struct packed {
    op_kind_e kind;
    role_e    src;
    role_e    dst;
  } uop_t;

  localparam int STEPS_PER_BIT = 23;

  function automatic uop_t mk(op_kind_e k, role_e s, role_e d);
    uop_t u;
    u.kind = k;
    u.src  = s;
    u.dst  = d;
    return u;
  endfunction

  // One-bit program: sum lands in M3, carry-out in C.
  function automatic uop_t uop_at(int step);
    case (step)
      0:       return mk(OP_CLEAR, ROLE_NONE, ROLE_M1);
      1:       return mk(OP_CLEAR, ROLE_NONE, ROLE_M2);
      2:       return mk(OP_CLEAR, ROLE_NONE, ROLE_M3);
      3:       return mk(OP_IMPLY, ROLE_A,    ROLE_M3);
      4:       return mk(OP_IMPLY, ROLE_B,    ROLE_M2);
      5:       return mk(OP_IMPLY, ROLE_M3,   ROLE_B);
      6:       return mk(OP_IMPLY, ROLE_A,    ROLE_M2);
      7:       return mk(OP_IMPLY, ROLE_M2,   ROLE_M1);
      8:       return mk(OP_IMPLY, ROLE_B,    ROLE_M1);
      9:       return mk(OP_CLEAR, ROLE_NONE, ROLE_A);
      10:      return mk(OP_IMPLY, ROLE_M1,   ROLE_A);
      11:      return mk(OP_CLEAR, ROLE_NONE, ROLE_B);
      12:      return mk(OP_CLEAR, ROLE_NONE, ROLE_M3);
      13:      return mk(OP_IMPLY, ROLE_C,    ROLE_M3);
      14:      return mk(OP_IMPLY, ROLE_M3,   ROLE_A);
      15:      return mk(OP_IMPLY, ROLE_C,    ROLE_M1);
      16:      return mk(OP_IMPLY, ROLE_M1,   ROLE_B);
      17:      return mk(OP_IMPLY, ROLE_A,    ROLE_B);
      18:      return mk(OP_CLEAR, ROLE_NONE, ROLE_M3);
      19:      return mk(OP_IMPLY, ROLE_B,    ROLE_M3);
      20:      return mk(OP_CLEAR, ROLE_NONE, ROLE_C);
      21:      return mk(OP_IMPLY, ROLE_M2,   ROLE_C);
      22:      return mk(OP_IMPLY, ROLE_M1,   ROLE_C);
      default: return mk(OP_CLEAR, ROLE_NONE, ROLE_NONE);
    endcase
  endfunction

  // Physical cell of a logical role for bit position b.
  function automatic int cell_of(role_e r, int b);
    case (r)
      ROLE_C:  return 0;
      ROLE_A:  return 3 * b + 3;
      ROLE_B:  return 3 * b + 4;
      ROLE_M3: return 3 * b + 5;
      ROLE_M1: return (b == 0) ? 1 : 3 * b;
      ROLE_M2: return (b == 0) ? 2 : 3 * b + 1;
      default: return 0;
    endcase
  endfunction

  // Sum cell of bit b; never used as scratch later.
  function automatic int sum_cell(int b);
    return 3 * b + 5;
  endfunction

endpackage

// File: rtl/imp_sequencer.sv
module imp_sequencer #(
  parameter int WIDTH = 8,
  parameter int BIT_W = 3,
  parameter int STEP_W = 5,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              load,
  output logic              last_step,
  output logic [BIT_W-1:0]  bit_idx,
  output logic [STEP_W-1:0] step_idx,
  output logic [CNT_W-1:0]  step_count
);
  import imp_pkg::*;

  localparam int TOTAL = WIDTH * STEPS_PER_BIT;

  logic bit_end;

  assign load      = start & ~busy;
  assign bit_end   = (step_idx == STEP_W'(STEPS_PER_BIT - 1));
  assign last_step = busy & bit_end & (bit_idx == BIT_W'(WIDTH - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      bit_idx    <= '0;
      step_idx   <= '0;
      step_count <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy       <= 1'b1;
          bit_idx    <= '0;
          step_idx   <= '0;
          step_count <= '0;
        end
      end else begin
        step_count <= step_count + CNT_W'(1);
        if (bit_end) begin
          step_idx <= '0;
          if (last_step) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bit_idx <= bit_idx + BIT_W'(1);
          end
        end else begin
          step_idx <= step_idx + STEP_W'(1);
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_DONE_AFTER_ALL: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && step_count == CNT_W'(TOTAL))); // R6
  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n) load |=> (busy && step_count == '0)); // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (busy && start && !last_step) |=> (busy && step_count == $past(step_count) + CNT_W'(1))); // R8
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n) last_step |=> (done && !busy)); // R7

endmodule

// File: rtl/imp_decoder.sv
module imp_decoder #(
  parameter int BIT_W = 3,
  parameter int STEP_W = 5,
  parameter int IDX_W = 5
) (
  input  logic [BIT_W-1:0]  bit_idx,
  input  logic [STEP_W-1:0] step_idx,
  output logic              kind,
  output logic [IDX_W-1:0]  p_idx,
  output logic [IDX_W-1:0]  q_idx
);
  import imp_pkg::*;

  uop_t cur;

  always_comb begin
    cur   = uop_at(int'(step_idx));
    kind  = cur.kind;
    q_idx = IDX_W'(cell_of(cur.dst, int'(bit_idx)));
    if (cur.kind == OP_IMPLY) p_idx = IDX_W'(cell_of(cur.src, int'(bit_idx)));
    else                      p_idx = '0;
  end

endmodule

// File: rtl/imp_cell_row.sv
module imp_cell_row #(
  parameter int WIDTH = 8,
  parameter int CELLS = 27,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  logic             exec,
  input  logic             kind,
  input  logic [IDX_W-1:0] p_idx,
  input  logic [IDX_W-1:0] q_idx,
  output logic [WIDTH-1:0] sum_cells,
  output logic             carry_cell
);
  import imp_pkg::*;

  logic [CELLS-1:0] cells;
  logic [CELLS-1:0] load_vec;
  logic             p_val;
  logic             q_val;
  logic             do_imply;
  logic             do_clear;

  assign load_vec[0] = cin;
  assign load_vec[1] = 1'b0;
  assign load_vec[2] = 1'b0;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    assign load_vec[3*g+3] = a[g];
    assign load_vec[3*g+4] = b[g];
    assign load_vec[3*g+5] = 1'b0;
    assign sum_cells[g]    = cells[3*g+5];
  end

  assign carry_cell = cells[0];
  assign p_val      = cells[p_idx];
  assign q_val      = cells[q_idx];
  assign do_imply   = exec & (kind == OP_IMPLY);
  assign do_clear   = exec & (kind == OP_CLEAR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cells <= '0;
    end else if (load) begin
      cells <= load_vec;
    end else if (do_imply) begin
      cells[q_idx] <= ~p_val | q_val;
    end else if (do_clear) begin
      cells[q_idx] <= 1'b0;
    end
  end

  AST_IMPLY_KEEPS_SET: assert property (@(posedge clk) disable iff (!rst_n) (do_imply && q_val) |=> cells[$past(q_idx)]); // R1
  AST_IMPLY_SETS_ON_ZERO_P: assert property (@(posedge clk) disable iff (!rst_n) (do_imply && !p_val) |=> cells[$past(q_idx)]); // R1
  AST_IMPLY_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n) do_imply |=> (cells[$past(p_idx)] == $past(p_val))); // R1
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) do_clear |=> !cells[$past(q_idx)]); // R2
  AST_DISTINCT_CELLS: assert property (@(posedge clk) disable iff (!rst_n) do_imply |-> (p_idx != q_idx)); // R4
  AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n) exec |-> (int'(q_idx) < CELLS)); // R4

endmodule

// File: rtl/imply_serial_adder.sv
module imply_serial_adder #(
  parameter  int WIDTH  = 8,
  localparam int CELLS  = 3 * WIDTH + 3,
  localparam int IDX_W  = $clog2(CELLS),
  localparam int CNT_W  = $clog2(WIDTH * imp_pkg::STEPS_PER_BIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             trace_valid,
  output logic             trace_kind,
  output logic [IDX_W-1:0] trace_p,
  output logic [IDX_W-1:0] trace_q,
  output logic [CNT_W-1:0] step_count
);
  import imp_pkg::*;

  localparam int BIT_W  = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int STEP_W = $clog2(STEPS_PER_BIT);

  logic              load;
  logic              last_step;
  logic [BIT_W-1:0]  bit_idx;
  logic [STEP_W-1:0] step_idx;
  logic              kind;
  logic [IDX_W-1:0]  p_idx;
  logic [IDX_W-1:0]  q_idx;
  logic [IDX_W-1:0]  prev_sum_idx;

  imp_sequencer #(
    .WIDTH(WIDTH), .BIT_W(BIT_W), .STEP_W(STEP_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .busy(busy), .done(done), .load(load), .last_step(last_step),
    .bit_idx(bit_idx), .step_idx(step_idx), .step_count(step_count)
  );

  imp_decoder #(
    .BIT_W(BIT_W), .STEP_W(STEP_W), .IDX_W(IDX_W)
  ) u_dec (
    .bit_idx(bit_idx), .step_idx(step_idx),
    .kind(kind), .p_idx(p_idx), .q_idx(q_idx)
  );

  imp_cell_row #(
    .WIDTH(WIDTH), .CELLS(CELLS), .IDX_W(IDX_W)
  ) u_row (
    .clk(clk), .rst_n(rst_n), .load(load),
    .a(op_a), .b(op_b), .cin(carry_in),
    .exec(busy), .kind(kind), .p_idx(p_idx), .q_idx(q_idx),
    .sum_cells(sum), .carry_cell(carry_out)
  );

  assign trace_valid  = busy;
  assign trace_kind   = busy ? kind : 1'b0;
  assign trace_p      = busy ? p_idx : '0;
  assign trace_q      = busy ? q_idx : '0;
  assign prev_sum_idx = IDX_W'(sum_cell(int'(bit_idx) - 1));

  AST_SUM_CELL_KEPT: assert property (@(posedge clk) disable iff (!rst_n) (busy && bit_idx != '0) |-> (q_idx != prev_sum_idx)); // R4
  AST_SUM_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start && !$past(busy)) |=> $stable(sum)); // R9

endmodule

// File: tb/imply_serial_adder_test.sv
module imply_serial_adder_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int NC = 27;
  localparam int TOTAL = 184;

  // kind*100 + p*10 + q ; roles 0=A 1=B 2=C 3=M1 4=M2 5=M3, p=9 means none
  localparam int SCHED [23] = '{93, 94, 95, 105, 114, 151, 104, 143, 113, 90, 130, 91,
                                95, 125, 150, 123, 131, 101, 95, 115, 92, 142, 132};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic carry_in = 1'b0;
  logic busy, done, carry_out, trace_valid, trace_kind;
  logic [W-1:0] sum;
  logic [4:0] trace_p, trace_q;
  logic [7:0] step_count;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  imply_serial_adder uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .carry_in(carry_in), .busy(busy), .done(done), .sum(sum),
    .carry_out(carry_out), .trace_valid(trace_valid), .trace_kind(trace_kind),
    .trace_p(trace_p), .trace_q(trace_q), .step_count(step_count)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<150000", cycles);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] tb_cell(int role, int b);
    case (role)
      0: return 5'(3 * b + 3);
      1: return 5'(3 * b + 4);
      2: return 5'd0;
      3: return (b == 0) ? 5'd1 : 5'(3 * b);
      4: return (b == 0) ? 5'd2 : 5'(3 * b + 1);
      5: return 5'(3 * b + 5);
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic [8:0] visible(logic [NC-1:0] m);
    logic [8:0] v;
    v[8] = m[0];
    for (int i = 0; i < W; i++) v[i] = m[3 * i + 5];
    return v;
  endfunction

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && trace_valid == 1'b0, "R10", "control after reset",
        {busy, done, trace_valid}, 0);
    chk(step_count == 8'd0, "R10", "step_count after reset", step_count, 0);
    chk({carry_out, sum} == 9'd0, "R10", "result after reset", {carry_out, sum}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // inject: step index at which a second start with other operands is driven (-1: none)
  task automatic run_add(input logic [W-1:0] a, input logic [W-1:0] b, input logic ci,
                         input int inject);
    logic [NC-1:0] mdl;
    logic [8:0] expect_res;
    int kind, pr, qr, bt, st;
    logic [4:0] pi, qi;
    op_a = a; op_b = b; carry_in = ci; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mdl = '0;
    mdl[0] = ci;
    for (int i = 0; i < W; i++) begin
      mdl[3 * i + 3] = a[i];
      mdl[3 * i + 4] = b[i];
    end
    chk(busy == 1'b1 && step_count == 8'd0, "R5", "busy after load", {busy, step_count}, 9'h100);
    chk({carry_out, sum} == visible(mdl), "R5", "cells after load", {carry_out, sum}, visible(mdl));
    for (int k = 0; k < TOTAL; k++) begin
      bt = k / 23;
      st = k % 23;
      if (k == inject) begin
        start = 1'b1; op_a = ~a; op_b = ~b; carry_in = ~ci;
      end else begin
        start = 1'b0;
      end
      kind = SCHED[st] / 100;
      pr = (SCHED[st] / 10) % 10;
      qr = SCHED[st] % 10;
      qi = tb_cell(qr, bt);
      pi = (kind == 1) ? tb_cell(pr, bt) : 5'd0;
      chk(busy && trace_valid && step_count == 8'(k), "R6", "busy and step_count mid-run",
          step_count, k);
      chk(trace_kind == kind[0] && trace_p == pi && trace_q == qi, "R3 R4", "trace step",
          {trace_kind, trace_p, trace_q}, {kind[0], pi, qi});
      if (kind == 1) mdl[qi] = ~mdl[pi] | mdl[qi];
      else           mdl[qi] = 1'b0;
      @(negedge clk);
      if (kind == 1)
        chk({carry_out, sum} == visible(mdl), "R1", "cells after implication",
            {carry_out, sum}, visible(mdl));
      else
        chk({carry_out, sum} == visible(mdl), "R2", "cells after clear",
            {carry_out, sum}, visible(mdl));
    end
    start = 1'b0;
    op_a = a; op_b = b; carry_in = ci;
    expect_res = {1'b0, a} + {1'b0, b} + 9'(ci);
    chk(done == 1'b1 && busy == 1'b0, "R7", "done pulse", {done, busy}, 2'b10);
    chk(step_count == 8'(TOTAL), "R6", "cycles per add", step_count, TOTAL);
    chk({carry_out, sum} == expect_res, "R9", "sum and carry", {carry_out, sum}, expect_res);
    if (inject >= 0)
      chk({carry_out, sum} == expect_res, "R8", "start while busy ignored",
          {carry_out, sum}, expect_res);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R7", "done one cycle", {done, busy}, 0);
    chk({carry_out, sum} == expect_res, "R9", "result held", {carry_out, sum}, expect_res);
  endtask

  initial begin
    test_reset();
    run_add(8'h00, 8'h00, 1'b0, -1);   // all zero
    run_add(8'hFF, 8'hFF, 1'b1, -1);   // all one
    run_add(8'hFF, 8'h00, 1'b1, -1);   // full carry ripple
    run_add(8'h01, 8'hFF, 1'b0, -1);   // ripple from bit 0
    run_add(8'hAA, 8'h55, 1'b1, -1);
    run_add(8'h80, 8'h80, 1'b0, -1);   // carry out of bit 7 only
    run_add(8'h3C, 8'h5A, 1'b0, 50);   // R8: start during run
    run_add(8'h7E, 8'h81, 1'b1, 183);  // R8: start on final step
    for (int r = 0; r < 6; r++)
      run_add(8'($urandom), 8'($urandom), 1'($urandom), -1);
    finish_run();
  end

endmodule